// File: doc/BRIEF.md
# Radix-4 Multiply-Add Tile

This tile forms a 16-bit result from two 8-bit operands and an 8-bit addend: the product of the multiplier operand and the multiplicand operand, plus the addend. Two configuration inputs pick the number format of each operand on its own. Each operand can be two's-complement or plain unsigned, so one tile covers signed, unsigned and mixed-sign multiplication. Because the addend feeds the reduction directly, a multiply-accumulate takes the same single pass as a plain multiply.

Inside, the first operand is recoded into radix-4 signed digits. Each digit picks zero, once or twice the second operand, either added or subtracted. When the first operand is unsigned, a fifth digit handles its top bit. The partial-product rows, the addend and a row of negation carry-ins go through a carry-save chain. One carry-propagate adder then resolves them, and a register captures the result. A valid flag travels alongside the data, with one cycle of latency.

Top module: `r4mac_tile`

## Requirements
- R1: With `a_signed`=0 and `b_signed`=0, `q` equals `a*b + s` with all three read as unsigned values, taken modulo 2^16.
- R2: With `a_signed`=1, operand `a` is read as two's-complement (bit 7 is the sign); with `a_signed`=0 an `a` of 128 or more is read as a positive value.
- R3: With `b_signed`=1, operand `b` is read as two's-complement; with `b_signed`=0 it is read as unsigned.
- R4: The addend `s` is sign-extended to 16 bits when `b_signed`=1 and zero-extended when `b_signed`=0.
- R5: A negative result appears on `q` as its 16-bit two's-complement pattern, for example 0xFF80 for 1*0 + (-128).
- R6: Inputs are sampled on the rising clock edge at which `in_valid`=1. `q` and `out_valid`=1 are presented after that edge and hold until the next edge, which gives one cycle of latency, and back-to-back operations are accepted on every cycle.
- R7: A rising edge with `in_valid`=0 drives `out_valid` to 0 and leaves `q` unchanged, whatever the other inputs are.
- R8: A rising edge with `rst_n`=0 clears `out_valid` and `q` to 0.
- R9: With `a`=0 the result is the extended addend alone, for any `b`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands present; sample them on this edge |
| a_signed | input | 1 | 1: `a` is two's-complement |
| b_signed | input | 1 | 1: `b` and `s` are two's-complement |
| a | input | 8 | Recoded multiplier operand |
| b | input | 8 | Multiplicand operand |
| s | input | 8 | Addend |
| out_valid | output | 1 | `q` holds a fresh result |
| q | output | 16 | Registered result a*b+s modulo 2^16 |

## Verification
Every result is due one rising edge after the edge that samples its operands. The bench drives inputs on falling edges and reads `q` and `out_valid` on the next falling edge, half a cycle after the capturing edge. The idle and reset checks read the outputs on the falling edge after a single rising edge that had `in_valid` or `rst_n` low. The back-to-back test drives a new operand set on the same falling edge where it checks the previous result. This proves that each result stays up for exactly one cycle before the next one replaces it.

// File: rtl/r4mac_pkg.sv
package r4mac_pkg;

  // Selection produced by one radix-4 digit: magnitude 1, magnitude 2, subtract.
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } r4_sel_t;

  // Recode an overlapping 3-bit window {hi, mid, lo} into a signed digit
  // worth -2*hi + mid + lo.
  function automatic r4_sel_t r4_decode(input logic [2:0] win);
    r4_sel_t sel;
    sel.one = win[1] ^ win[0];
    sel.two = (win[2] & ~win[1] & ~win[0]) | (~win[2] & win[1] & win[0]);
    sel.neg = win[2] & ~(win[1] & win[0]);
    return sel;
  endfunction

endpackage

// File: rtl/r4mac_pp_gen.sv
module r4mac_pp_gen #(
  parameter int OPW   = 8,
  parameter int QW    = 16,
  parameter int SHIFT = 0
) (
  input  logic [2:0]     win,
  input  logic [OPW-1:0] mcand,
  input  logic           mcand_signed,
  output logic [QW-1:0]  row,
  output logic           neg
);
  import r4mac_pkg::*;

  r4_sel_t            sel;
  logic [QW-1:0]      mcand_ext;
  logic [QW-1:0]      magnitude;

  assign sel       = r4_decode(win);
  assign mcand_ext = {{(QW-OPW){mcand_signed & mcand[OPW-1]}}, mcand};

  always_comb begin
    if (sel.two)      magnitude = mcand_ext << 1;
    else if (sel.one) magnitude = mcand_ext;
    else              magnitude = '0;
  end

  // Subtraction is done as one's complement here; the +1 enters through
  // the separate correction row at bit position SHIFT.
  assign row = (sel.neg ? ~magnitude : magnitude) << SHIFT;
  assign neg = sel.neg;

  always_comb begin
    AST_ONE_MAGNITUDE: assert ($onehot0({sel.one, sel.two}));  // R2
    AST_NEG_HAS_MAGNITUDE: assert (!sel.neg || sel.one || sel.two);  // R2
  end

endmodule

// File: rtl/r4mac_csa_chain.sv
module r4mac_csa_chain #(
  parameter int W    = 16,
  parameter int ROWS = 7
) (
  input  logic [ROWS-1:0][W-1:0] rows,
  output logic [W-1:0]           sum_vec,
  output logic [W-1:0]           carry_vec
);
  localparam int STAGES = ROWS - 2;

  logic [STAGES:0][W-1:0] s_chain;
  logic [STAGES:0][W-1:0] c_chain;

  assign s_chain[0] = rows[0];
  assign c_chain[0] = rows[1];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic [W-1:0] x, y, z;
    assign x = s_chain[k];
    assign y = c_chain[k];
    assign z = rows[k+2];
    assign s_chain[k+1] = x ^ y ^ z;
    assign c_chain[k+1] = ((x & y) | (x & z) | (y & z)) << 1;
  end

  assign sum_vec   = s_chain[STAGES];
  assign carry_vec = c_chain[STAGES];

  always_comb begin : chk_sum
    logic [W-1:0] plain;
    plain = '0;
    for (int r = 0; r < ROWS; r++) plain = plain + rows[r];
    AST_CSA_KEEPS_SUM: assert (sum_vec + carry_vec == plain);  // R1
  end

endmodule

// File: rtl/r4mac_tile.sv
module r4mac_tile #(
  parameter int OPW = 8,
  parameter int SW  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 a_signed,
  input  logic                 b_signed,
  input  logic [OPW-1:0]       a,
  input  logic [OPW-1:0]       b,
  input  logic [SW-1:0]        s,
  output logic                 out_valid,
  output logic [2*OPW-1:0]     q
);
  localparam int QW    = 2 * OPW;
  localparam int NDIG  = OPW / 2 + 1;
  localparam int NROWS = NDIG + 2;
  localparam int AXW   = OPW + 3;

  // Multiplier operand with a zero below bit 0 and two extension bits on top.
  logic           a_top;
  logic [AXW-1:0] a_x;
  assign a_top = a_signed & a[OPW-1];
  assign a_x   = {a_top, a_top, a, 1'b0};

  logic [NROWS-1:0][QW-1:0] rows;
  logic [NDIG-1:0]          neg_bits;
  logic [QW-1:0]            corr_row;
  logic [QW-1:0]            s_ext;

  for (genvar d = 0; d < NDIG; d++) begin : g_digit
    r4mac_pp_gen #(
      .OPW   (OPW),
      .QW    (QW),
      .SHIFT (2 * d)
    ) u_pp (
      .win          (a_x[2*d+2 -: 3]),
      .mcand        (b),
      .mcand_signed (b_signed),
      .row          (rows[d]),
      .neg          (neg_bits[d])
    );
  end

  always_comb begin
    corr_row = '0;
    for (int d = 0; d < NDIG; d++) corr_row[2*d] = neg_bits[d];
  end

  assign s_ext           = {{(QW-SW){b_signed & s[SW-1]}}, s};
  assign rows[NDIG]      = s_ext;
  assign rows[NDIG+1]    = corr_row;

  logic [QW-1:0] sum_vec;
  logic [QW-1:0] carry_vec;
  logic [QW-1:0] q_next;

  r4mac_csa_chain #(
    .W    (QW),
    .ROWS (NROWS)
  ) u_reduce (
    .rows      (rows),
    .sum_vec   (sum_vec),
    .carry_vec (carry_vec)
  );

  assign q_next = sum_vec + carry_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q         <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) q <= q_next;
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R6
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R7
  AST_IDLE_HOLDS_Q: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(q));  // R7
  AST_ZERO_A_GIVES_S: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && a == '0) |=> q == $past(s_ext));  // R9
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && q == '0));  // R8

endmodule

// File: tb/r4mac_tile_tb_top.sv
module r4mac_tile_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int NVEC       = 10;
  localparam int NRAND      = 400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        a_signed = 1'b0;
  logic        b_signed = 1'b0;
  logic [7:0]  a = '0, b = '0, s = '0;
  logic        out_valid;
  logic [15:0] q;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  r4mac_tile dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a_signed(a_signed), .b_signed(b_signed),
    .a(a), .b(b), .s(s), .out_valid(out_valid), .q(q)
  );

  // Vector fields: {a_signed, b_signed, a, b, s}
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'd3,   8'd5,   8'd0},
    {1'b0, 1'b0, 8'd200, 8'd150, 8'd77},
    {1'b1, 1'b0, 8'hF6,  8'd12,  8'd4},
    {1'b1, 1'b1, 8'hF6,  8'hFD,  8'hFF},
    {1'b0, 1'b1, 8'd130, 8'hFE,  8'h10},
    {1'b1, 1'b1, 8'h80,  8'h80,  8'h7F},
    {1'b0, 1'b0, 8'hFF,  8'hFF,  8'hFF},
    {1'b1, 1'b1, 8'h55,  8'hAA,  8'h80},
    {1'b0, 1'b1, 8'hAA,  8'h55,  8'h33},
    {1'b1, 1'b0, 8'h7F,  8'hC3,  8'hC3}
  };

  function automatic logic [15:0] model(bit ma, bit mb, logic [7:0] av,
                                        logic [7:0] bv, logic [7:0] sv);
    int x, y, z, r;
    x = ma ? int'($signed(av)) : int'(av);
    y = mb ? int'($signed(bv)) : int'(bv);
    z = mb ? int'($signed(sv)) : int'(sv);
    r = x * y + z;
    return r[15:0];
  endfunction

  function automatic string mode_req(bit ma, bit mb);
    if (ma) return "R2";
    if (mb) return "R3";
    return "R1";
  endfunction

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%04h expected 0x%04h", req, what, act, exp);
    end
  endtask

  task automatic run_op(bit ma, bit mb, logic [7:0] av, logic [7:0] bv,
                        logic [7:0] sv, string req);
    @(negedge clk);
    a_signed = ma; b_signed = mb; a = av; b = bv; s = sv; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R6", "out_valid after op", {15'd0, out_valid}, 16'd1);
    check(req, $sformatf("q ma=%0d mb=%0d a=%02h b=%02h s=%02h", ma, mb, av, bv, sv),
          q, model(ma, mb, av, bv, sv));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] corner [4];
    logic [31:0] lfsr;
    logic [15:0] held;
    corner[0] = 8'h00; corner[1] = 8'h7F; corner[2] = 8'h80; corner[3] = 8'hFF;

    // Reset state (R8)
    repeat (3) @(negedge clk);
    check("R8", "out_valid in reset", {15'd0, out_valid}, 16'd0);
    check("R8", "q in reset", q, 16'd0);
    rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      run_op(VEC[i][25], VEC[i][24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0],
             mode_req(VEC[i][25], VEC[i][24]));
    end

    // Corner operands in every mode
    for (int m = 0; m < 4; m++)
      for (int ai = 0; ai < 4; ai++)
        for (int bi = 0; bi < 4; bi++)
          run_op(m[1], m[0], corner[ai], corner[bi], corner[(ai + bi) % 4],
                 mode_req(m[1], m[0]));

    // R2: unsigned a of 128 or more stays positive
    run_op(1'b0, 1'b0, 8'h80, 8'd2, 8'd0, "R2");
    check("R2", "unsigned 0x80*2", q, 16'd256);
    // R3: b sign selection
    run_op(1'b0, 1'b1, 8'd1, 8'hFF, 8'd0, "R3");
    check("R3", "signed b -1", q, 16'hFFFF);
    // R4: addend extension
    run_op(1'b0, 1'b1, 8'd0, 8'd0, 8'h80, "R4");
    check("R4", "s sign-extended", q, 16'hFF80);
    run_op(1'b0, 1'b0, 8'd0, 8'd0, 8'h80, "R4");
    check("R4", "s zero-extended", q, 16'h0080);
    // R5: negative result pattern
    run_op(1'b1, 1'b1, 8'd1, 8'd0, 8'h80, "R5");
    check("R5", "1*0-128", q, 16'hFF80);
    // R9: zero a passes s
    run_op(1'b1, 1'b1, 8'd0, 8'hA7, 8'h3C, "R9");
    check("R9", "a=0 gives s", q, 16'h003C);

    // R7: idle cycle keeps q and drops out_valid
    held = q;
    a = 8'h12; b = 8'h34; s = 8'h56;
    @(negedge clk);
    check("R7", "out_valid idle", {15'd0, out_valid}, 16'd0);
    check("R7", "q held idle", q, held);

    // R6: back-to-back operations
    @(negedge clk);
    a_signed = 1'b0; b_signed = 1'b0; a = 8'd10; b = 8'd11; s = 8'd1; in_valid = 1'b1;
    @(negedge clk);
    check("R6", "first of pair", q, model(0, 0, 8'd10, 8'd11, 8'd1));
    a_signed = 1'b1; b_signed = 1'b1; a = 8'hF0; b = 8'd3; s = 8'd2;
    @(negedge clk);
    in_valid = 1'b0;
    check("R6", "second of pair", q, model(1, 1, 8'hF0, 8'd3, 8'd2));
    check("R6", "valid second of pair", {15'd0, out_valid}, 16'd1);

    // Random operands in all modes
    lfsr = 32'h1D2C3B4A;
    for (int i = 0; i < NRAND; i++) begin
      lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
      run_op(lfsr[25], lfsr[24], lfsr[23:16], lfsr[15:8], lfsr[7:0],
             mode_req(lfsr[25], lfsr[24]));
    end

    // R8: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8", "out_valid after reset", {15'd0, out_valid}, 16'd0);
    check("R8", "q after reset", q, 16'd0);
    rst_n = 1'b1;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule